// File: doc/BRIEF.md
# Multicart Bank Controller with Soft-Reset Counter

This block sits on the cartridge side of an 8-bit console bus and turns CPU writes into bank selections. A single control byte, loaded by a CPU write to one address in the 0x6000–0x7FFF window, sets several outputs. It picks the PRG ROM layout for the 0x8000–0xFFFF window, either one 32 KB bank or a 16 KB bank mirrored into both halves. It also picks an 8 KB CHR bank and the nametable mirroring. The PRG outputs are always given as two 16 KB bank numbers, one for each half of the window, so the ROM address logic outside the block does not need to know which layout is active.

The block also holds a small counter that steps each time the console's soft reset is pressed. Power-on reset clears the counter. Soft reset does not clear it, and the counter wraps after four presses. Menu code reads the counter anywhere in 0x6000–0x7FFF to choose which game to boot. The block flags those reads as its own. All other reads go to ROM and are not driven here. Soft reset also returns the control byte to zero, which puts the board back into its menu mapping.

Top module: `multicart_mapper`

## Requirements
- R1: A CPU write (cpu_wr high at a clock edge) to address 0x6001 loads cpu_wdata into the 8-bit control byte.
- R2: Writes to every other address leave all mapping outputs unchanged. This includes 0x6000, 0x6002, 0x6003, 0x7001 and 0x8000–0xFFFF.
- R3: When control bit 4 is 1 (32 KB layout), prg_bank_lo = {ctrl[7:6],0} and prg_bank_hi = {ctrl[7:6],1}, both in 16 KB units.
- R4: When control bit 4 is 0 (16 KB layout), prg_bank_lo and prg_bank_hi both equal ctrl[7:5].
- R5: chr_bank equals the full control byte, as an 8 KB bank number.
- R6: mirror_horiz equals control bit 3: 1 selects horizontal mirroring and 0 selects vertical mirroring.
- R7: While cpu_rd is high and cpu_addr is in 0x6000–0x7FFF, rd_valid is 1 and rd_data is the counter, zero-extended into bits [1:0]. Otherwise rd_valid is 0 and rd_data is 0.
- R8: A soft reset (soft_rst high at a clock edge) increments the counter modulo 4 and clears the control byte. If a write arrives in the same cycle, the soft reset takes priority over it.
- R9: Power-on reset (rst high at a clock edge) clears the counter and the control byte. It takes priority over soft reset.
- R10: Mapping outputs are combinational from the control byte. They keep the old mapping during the write cycle and show the new mapping from the clock edge that ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| soft_rst | input | 1 | Console soft reset, synchronous, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| prg_bank_lo | output | 3 | 16 KB bank for 0x8000–0xBFFF |
| prg_bank_hi | output | 3 | 16 KB bank for 0xC000–0xFFFF |
| chr_bank | output | 8 | 8 KB CHR bank |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| rd_data | output | 8 | Read data for the counter window |
| rd_valid | output | 1 | Block drives rd_data this cycle |

## Verification
The control byte is loaded with values that alternate the layout bit while varying the upper bank bits and the mirroring bit. This separates a wrong layout choice from a wrong bit slice or a swapped half. Writes of all ones to neighbouring and ROM-window addresses must leave the mapping alone, which exposes a loose address decode. The counter is stepped through a full wrap, and reads are made at both ends of its window and just outside it. Both resets are also raised together with writes and with each other to confirm which one wins.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int PBANK_W = 3;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 16'h6001;

    typedef struct packed {
        logic [PBANK_W-1:0] prg_lo;
        logic [PBANK_W-1:0] prg_hi;
        logic [DATA_W-1:0]  chr;
        logic               mirror_h;
    } map_t;

    typedef enum logic [1:0] {
        WIN_OTHER = 2'd0,
        WIN_SRAM  = 2'd1,
        WIN_ROM   = 2'd2
    } win_e;

    function automatic win_e win_of(input logic [ADDR_W-1:0] a);
        if (a[15])
            return WIN_ROM;
        else if (a[15:13] == 3'b011)
            return WIN_SRAM;
        else
            return WIN_OTHER;
    endfunction

    function automatic map_t decode_ctrl(input logic [DATA_W-1:0] c);
        map_t m;
        if (c[4]) begin
            m.prg_lo = {c[7:6], 1'b0};
            m.prg_hi = {c[7:6], 1'b1};
        end else begin
            m.prg_lo = c[7:5];
            m.prg_hi = c[7:5];
        end
        m.chr      = c;
        m.mirror_h = c[3];
        return m;
    endfunction

endpackage

// File: rtl/mcm_ctrl_reg.sv
module mcm_ctrl_reg
    import mcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl
);

    logic load;
    assign load = wr_en && (addr == CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            ctrl <= '0;
        else if (load)
            ctrl <= wdata;
    end

    AST_SOFT_CLEARS_CTRL: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (ctrl == '0)) else $error("soft reset left ctrl set"); // R8

    AST_CTRL_LOADS: assert property (@(posedge clk) disable iff (rst)
        (!soft_rst && wr_en && addr == CTRL_ADDR) |=> (ctrl == $past(wdata))) else $error("ctrl load lost"); // R1

    AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!soft_rst && !(wr_en && addr == CTRL_ADDR)) |=> $stable(ctrl)) else $error("ctrl changed without load"); // R2

endmodule

// File: rtl/mcm_reset_counter.sv
module mcm_reset_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (soft_rst)
            cnt <= cnt + 1'b1;
    end

    AST_CNT_STEPS: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (cnt == $past(cnt) + 1'b1)) else $error("counter did not step"); // R8

    AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !soft_rst |=> $stable(cnt)) else $error("counter moved without soft reset"); // R8

endmodule

// File: rtl/mcm_read_port.sv
module mcm_read_port
    import mcm_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int PAD_W = DATA_W - CNT_W;

    always_comb begin
        rd_valid = rd_en && (win_of(addr) == WIN_SRAM);
        rd_data  = rd_valid ? {{PAD_W{1'b0}}, cnt} : '0;
    end

endmodule

// File: rtl/multicart_mapper.sv
module multicart_mapper
    import mcm_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic [15:0]        cpu_addr,
    input  logic [7:0]         cpu_wdata,
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    output logic [2:0]         prg_bank_lo,
    output logic [2:0]         prg_bank_hi,
    output logic [7:0]         chr_bank,
    output logic               mirror_horiz,
    output logic [7:0]         rd_data,
    output logic               rd_valid
);

    logic [DATA_W-1:0] ctrl;
    logic [CNT_W-1:0]  cnt;
    map_t              map;

    mcm_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .wr_en    (cpu_wr),
        .addr     (cpu_addr),
        .wdata    (cpu_wdata),
        .ctrl     (ctrl)
    );

    mcm_reset_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .cnt      (cnt)
    );

    mcm_read_port #(.CNT_W(CNT_W)) u_rd (
        .rd_en    (cpu_rd),
        .addr     (cpu_addr),
        .cnt      (cnt),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign map          = decode_ctrl(ctrl);
    assign prg_bank_lo  = map.prg_lo;
    assign prg_bank_hi  = map.prg_hi;
    assign chr_bank     = map.chr;
    assign mirror_horiz = map.mirror_h;

    AST_WIDE_PAIRS_HALVES: assert property (@(posedge clk) disable iff (rst)
        chr_bank[4] |-> (!prg_bank_lo[0] && prg_bank_hi[0] && prg_bank_lo[2:1] == prg_bank_hi[2:1]))
        else $error("32 KB halves not paired"); // R3

    AST_NARROW_SAME_BANK: assert property (@(posedge clk) disable iff (rst)
        !chr_bank[4] |-> (prg_bank_lo == prg_bank_hi)) else $error("16 KB halves differ"); // R4

    AST_MIRROR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        mirror_horiz == chr_bank[3]) else $error("mirror bit mismatch"); // R6

    AST_READ_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_data[7:CNT_W] == '0)) else $error("read data upper bits set"); // R7

    AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0)) else $error("read data driven while idle"); // R7

endmodule

// File: tb/multicart_mapper_bench.sv
`timescale 1ns/100ps
module multicart_mapper_bench;

    typedef struct {
        logic [2:0] lo;
        logic [2:0] hi;
        logic [7:0] chr;
        logic       mh;
        logic       rv;
        logic [7:0] rd;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [2:0]  prg_bank_lo, prg_bank_hi;
    logic [7:0]  chr_bank, rd_data;
    logic        mirror_horiz, rd_valid;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    logic [7:0] m_ctrl = 8'h00;
    logic [1:0] m_cnt = 2'd0;

    always #2.5 clk = ~clk;

    multicart_mapper u_multicart_mapper (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .prg_bank_lo(prg_bank_lo), .prg_bank_hi(prg_bank_hi), .chr_bank(chr_bank),
        .mirror_horiz(mirror_horiz), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic push_exp(input string tag, input logic rv, input logic [7:0] rd);
        exp_t e;
        if (m_ctrl[4]) begin
            e.lo = {m_ctrl[7:6], 1'b0};
            e.hi = {m_ctrl[7:6], 1'b1};
        end else begin
            e.lo = m_ctrl[7:5];
            e.hi = m_ctrl[7:5];
        end
        e.chr = m_ctrl;
        e.mh  = m_ctrl[3];
        e.rv  = rv;
        e.rd  = rd;
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compare at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (prg_bank_lo !== e.lo || prg_bank_hi !== e.hi || chr_bank !== e.chr ||
                mirror_horiz !== e.mh || rd_valid !== e.rv || rd_data !== e.rd) begin
                bad++;
                $display("FAIL %s: actual lo=%0d hi=%0d chr=%02h mh=%0b rv=%0b rd=%02h expected lo=%0d hi=%0d chr=%02h mh=%0b rv=%0b rd=%02h",
                         e.tag, prg_bank_lo, prg_bank_hi, chr_bank, mirror_horiz, rd_valid, rd_data,
                         e.lo, e.hi, e.chr, e.mh, e.rv, e.rd);
            end
        end
    end

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string tag);
        @(posedge clk); #1;
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        push_exp({tag, " R10 old map during write"}, 1'b0, 8'h00);
        @(posedge clk); #1;
        cpu_wr = 1'b0;
        if (a == 16'h6001) m_ctrl = d;
        push_exp(tag, 1'b0, 8'h00);
    endtask

    task automatic do_read(input logic [15:0] a, input logic strobe, input string tag);
        logic hit;
        @(posedge clk); #1;
        cpu_addr = a; cpu_rd = strobe;
        hit = strobe && (a >= 16'h6000) && (a <= 16'h7FFF);
        push_exp(tag, hit, hit ? {6'b0, m_cnt} : 8'h00);
        @(posedge clk); #1;
        cpu_rd = 1'b0;
    endtask

    // drive resets for one edge, optionally with a write to 0x6001 in the same cycle
    task automatic do_reset(input logic p, input logic s, input logic w, input logic [7:0] d, input string tag);
        @(posedge clk); #1;
        rst = p; soft_rst = s;
        cpu_addr = 16'h6001; cpu_wdata = d; cpu_wr = w;
        @(posedge clk); #1;
        rst = 1'b0; soft_rst = 1'b0; cpu_wr = 1'b0;
        if (p) begin
            m_cnt = 2'd0; m_ctrl = 8'h00;
        end else if (s) begin
            m_cnt = m_cnt + 2'd1; m_ctrl = 8'h00;
        end else if (w) begin
            m_ctrl = d;
        end
        push_exp(tag, 1'b0, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        push_exp("R9 reset state", 1'b0, 8'h00);

        do_write(16'h6001, 8'hD5, "R1 R3 R5 R6 wide layout vertical");
        do_write(16'h6001, 8'hA8, "R1 R4 R6 narrow layout horizontal");
        do_write(16'h6001, 8'h5C, "R3 R6 wide layout horizontal");
        do_write(16'h6001, 8'h2F, "R4 R5 narrow bank 1");

        do_write(16'h6002, 8'hFF, "R2 write 6002 ignored");
        do_write(16'h6000, 8'hFF, "R2 write 6000 ignored");
        do_write(16'h6003, 8'hFF, "R2 write 6003 ignored");
        do_write(16'h7001, 8'hFF, "R2 write 7001 ignored");
        do_write(16'h8000, 8'hFF, "R2 write 8000 ignored");
        do_write(16'hFFFF, 8'hFF, "R2 write FFFF ignored");

        do_read(16'h6000, 1'b1, "R7 read low end");
        do_read(16'h7FFF, 1'b1, "R7 read high end");
        do_read(16'h8000, 1'b1, "R7 read rom not driven");
        do_read(16'h5FFF, 1'b1, "R7 read below window");
        do_read(16'h6000, 1'b0, "R7 no strobe");

        for (int i = 0; i < 4; i++) begin
            do_write(16'h6001, 8'h93, "R1 reload before soft reset");
            do_reset(1'b0, 1'b1, 1'b0, 8'h00, "R8 soft reset clears ctrl");
            do_read(16'h6ABC, 1'b1, "R8 R7 counter after soft reset");
        end

        do_reset(1'b0, 1'b1, 1'b1, 8'hF7, "R8 soft reset beats write");
        do_read(16'h7000, 1'b1, "R8 counter stepped once");
        do_write(16'h6001, 8'h66, "R1 reload before power reset");
        do_reset(1'b1, 1'b1, 1'b1, 8'h11, "R9 power reset beats soft and write");
        do_read(16'h6000, 1'b1, "R9 counter cleared");

        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule